// File: doc/BRIEF.md
# Forced-NOP Video Fetch Sequencer

The sequencer watches the opcode fetches of an 8-bit CPU. It runs on a clock at twice the CPU rate, so each clock period is half a T-state. When the fetch strobe falls, a small micro counter starts and marks out the eight half-T-states of the fetch. If the fetch is a display fetch, the block does three things:
- it captures the byte on the data bus as a character code;
- for one half-T-state it pulls every data line low, so the CPU reads opcode 0x00 (a NOP);
- during the refresh half of the fetch it drives a 9-bit character-pattern address made from that code and a scanline counter.

A display fetch is one with the address top bit high, the halt line inactive and data bit 6 clear.

The scanline counter is cleared by vertical sync and advances once per horizontal sync pulse. Only its three low bits form part of the address. Outside the refresh window the address lines are released: the enable is low and the value reads zero.

Top module: `vfetch_seq`

## Requirements
- R1: While reset is asserted and on the first clock after it, bus_pull_low, addr_oe and video_cycle are 0, char_code is 0 and rom_addr is 0.
- R2: The micro counter starts only on a clock edge that samples m1_n low after the previous edge sampled it high, and only when the counter is idle. That edge is count 0. The capture happens on the fourth edge after it (at count 3).
- R3: A fetch counts as a display fetch when m1_n is low, a15 is high, halt_n is high and data_in bit 6 is 0, all sampled at the capture edge. video_cycle is then 1 from the capture edge until the counter clears.
- R4: On a display fetch, char_code takes the value of data_in sampled at the capture edge, and keeps it until the next display fetch.
- R5: bus_pull_low is high for exactly one clock, count 4, which is the half-T-state after the capture.
- R6: addr_oe is high for exactly three clocks, counts 5, 6 and 7, and only during a display fetch.
- R7: While addr_oe is high, rom_addr[2:0] equals the scanline count and rom_addr[8:3] equals char_code[5:0].
- R8: While addr_oe is low, rom_addr is 0, which means the lines are released.
- R9: The scanline counter is cleared while vsync is high. Otherwise it increments on each rising edge of hsync and wraps from 7 to 0.
- R10: A fetch that is not a display fetch produces no bus_pull_low and no addr_oe, and leaves char_code unchanged.
- R11: The counter clears after count 7. If m1_n stays low past count 7, no new sequence starts until m1_n has gone high and then low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the CPU clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| m1_n | input | 1 | Opcode fetch strobe, active low |
| a15 | input | 1 | Top CPU address bit |
| halt_n | input | 1 | CPU halt status, active low |
| data_in | input | 8 | Data bus as seen by the block |
| vsync | input | 1 | Vertical sync, clears the scanline count |
| hsync | input | 1 | Horizontal sync pulse, advances the scanline count |
| bus_pull_low | output | 1 | Pull every data line low (forced NOP) |
| rom_addr | output | 9 | Character-pattern address for the refresh window |
| addr_oe | output | 1 | Drive enable for rom_addr |
| char_code | output | 8 | Last captured character code |
| video_cycle | output | 1 | Current fetch was taken as a display fetch |

## Verification
The bench looks for off-by-one timing. A capture one half-T-state late would latch the zeroed bus, and a force that lasts two clocks would overlap the refresh drive. It sends fetches that fail each qualifying condition in turn; a design that ignored halt_n or bit 6 would pull the bus low while the CPU is halted or on ordinary code. It holds the fetch strobe low well past count 7, which catches a counter that restarts on a level instead of an edge. It also wraps the scanline count past 7 and clears it with vsync, so an address built from the wrong bits or from a stale line count shows up on rom_addr.

// File: rtl/vfetch_pkg.sv
package vfetch_pkg;
  // Micro counter landmarks, in half-T-states from the start of the fetch
  localparam int unsigned MC_W      = 3;
  localparam int unsigned CAP_MC    = 3;
  localparam int unsigned FORCE_MC  = 4;
  localparam int unsigned DRIVE_LO  = 5;
  localparam int unsigned DRIVE_HI  = 7;

  // True when count lies in the closed window [lo, hi]
  function automatic logic in_window(input logic [MC_W-1:0] cnt,
                                     input int unsigned lo,
                                     input int unsigned hi);
    return (int'(cnt) >= int'(lo)) && (int'(cnt) <= int'(hi));
  endfunction
endpackage

// File: rtl/vfetch_micro_seq.sv
module vfetch_micro_seq
  import vfetch_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            m1_n,
  output logic            running,
  output logic [MC_W-1:0] count,
  output logic            start_evt,
  output logic            done_evt
);
  localparam logic [MC_W-1:0] LAST = {MC_W{1'b1}};

  logic m1_q;

  assign start_evt = !running && m1_q && !m1_n;
  assign done_evt  = running && (count == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m1_q    <= 1'b1;
      running <= 1'b0;
      count   <= '0;
    end else begin
      m1_q <= m1_n;
      if (start_evt) begin
        running <= 1'b1;
        count   <= '0;
      end else if (done_evt) begin
        running <= 1'b0;
        count   <= '0;
      end else if (running) begin
        count <= count + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vfetch_capture.sv
module vfetch_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_evt,
  input  logic              done_evt,
  input  logic [DATA_W-1:0] data_in,
  output logic              video,
  output logic [DATA_W-1:0] code
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      video <= 1'b0;
      code  <= '0;
    end else if (cap_evt) begin
      video <= 1'b1;
      code  <= data_in;
    end else if (done_evt) begin
      video <= 1'b0;
    end
  end
endmodule

// File: rtl/vfetch_line_ctr.sv
module vfetch_line_ctr #(
  parameter int unsigned LINE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync,
  input  logic              hsync,
  output logic [LINE_W-1:0] line,
  output logic              hs_rise
);
  logic hs_q;

  assign hs_rise = hsync && !hs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      line <= '0;
    end else begin
      hs_q <= hsync;
      if (vsync)        line <= '0;
      else if (hs_rise) line <= line + 1'b1;
    end
  end
endmodule

// File: rtl/vfetch_seq.sv
module vfetch_seq
  import vfetch_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 9,
  parameter int unsigned LINE_W   = 3,
  parameter int unsigned QUAL_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m1_n,
  input  logic              a15,
  input  logic              halt_n,
  input  logic [DATA_W-1:0] data_in,
  input  logic              vsync,
  input  logic              hsync,
  output logic              bus_pull_low,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              addr_oe,
  output logic [DATA_W-1:0] char_code,
  output logic              video_cycle
);
  localparam int unsigned CODE_BITS = ADDR_W - LINE_W;

  logic            running, start_evt, done_evt, cap_evt, hs_rise;
  logic [MC_W-1:0] count;
  logic [LINE_W-1:0] line;

  vfetch_micro_seq u_seq (
    .clk(clk), .rst_n(rst_n), .m1_n(m1_n),
    .running(running), .count(count),
    .start_evt(start_evt), .done_evt(done_evt)
  );

  assign cap_evt = running && (count == MC_W'(CAP_MC)) && !m1_n && a15
                   && halt_n && !data_in[QUAL_BIT];

  vfetch_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_evt(cap_evt), .done_evt(done_evt),
    .data_in(data_in), .video(video_cycle), .code(char_code)
  );

  vfetch_line_ctr #(.LINE_W(LINE_W)) u_line (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .hsync(hsync),
    .line(line), .hs_rise(hs_rise)
  );

  assign bus_pull_low = video_cycle && running && (count == MC_W'(FORCE_MC));
  assign addr_oe      = video_cycle && running && in_window(count, DRIVE_LO, DRIVE_HI);
  assign rom_addr     = addr_oe ? {char_code[CODE_BITS-1:0], line} : '0;
endmodule

// File: rtl/vfetch_seq_chk.sv
module vfetch_seq_chk #(
  parameter int unsigned LINE_W = 3,
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_pull_low,
  input logic              addr_oe,
  input logic              video_cycle,
  input logic [ADDR_W-1:0] rom_addr,
  input logic [DATA_W-1:0] char_code,
  input logic              cap_evt,
  input logic              hs_rise,
  input logic              vsync,
  input logic [LINE_W-1:0] line
);
  AST_FORCE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_pull_low |=> !bus_pull_low); // R5
  AST_FORCE_THEN_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_pull_low |=> addr_oe); // R6
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_pull_low && addr_oe)); // R5
  AST_DRIVE_NEEDS_VIDEO: assert property (@(posedge clk) disable iff (!rst_n)
    addr_oe |-> video_cycle); // R6
  AST_RELEASED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_oe |-> rom_addr == '0); // R8
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(char_code)); // R4
  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_rise && !vsync) |=> line == LINE_W'($past(line) + 1'b1)); // R9
  AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |=> line == '0); // R9
endmodule

bind vfetch_seq vfetch_seq_chk #(.LINE_W(LINE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_pull_low(bus_pull_low), .addr_oe(addr_oe),
  .video_cycle(video_cycle), .rom_addr(rom_addr), .char_code(char_code),
  .cap_evt(cap_evt), .hs_rise(hs_rise), .vsync(vsync), .line(line)
);

// File: tb/vfetch_seq_bench.sv
module vfetch_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m1_n = 1'b1, a15 = 1'b0, halt_n = 1'b1, vsync = 1'b0, hsync = 1'b0;
  logic [7:0] data_in = 8'h00;
  logic       bus_pull_low, addr_oe, video_cycle;
  logic [8:0] rom_addr;
  logic [7:0] char_code;

  int checks = 0, failures = 0;
  int force_cnt = 0, oe_cnt = 0;
  string scen = "R1 reset";

  always #5 clk = ~clk;

  vfetch_seq u_vfetch_seq (
    .clk(clk), .rst_n(rst_n), .m1_n(m1_n), .a15(a15), .halt_n(halt_n),
    .data_in(data_in), .vsync(vsync), .hsync(hsync),
    .bus_pull_low(bus_pull_low), .rom_addr(rom_addr), .addr_oe(addr_oe),
    .char_code(char_code), .video_cycle(video_cycle)
  );

  // Behavioural reference: phase -1 means idle
  int ph = -1, mcode = 0, mline = 0;
  bit mvid = 0, pm1 = 1, phs = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      ph = -1; mvid = 0; mcode = 0; mline = 0; pm1 = 1; phs = 0;
    end else begin
      if (ph < 0) begin
        if (pm1 && !m1_n) ph = 0;
      end else begin
        if (ph == 3 && !m1_n && a15 && halt_n && !data_in[6]) begin
          mvid = 1; mcode = data_in;
        end
        if (ph == 7) begin ph = -1; mvid = 0; end
        else ph = ph + 1;
      end
      if (vsync) mline = 0;
      else if (hsync && !phs) mline = (mline + 1) % 8;
      pm1 = m1_n; phs = hsync;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", req, scen, act, exp, $time);
    end
  endtask

  // Compare every cycle at the falling edge
  always @(negedge clk) begin
    bit e_force, e_oe;
    e_force = mvid && ph == 4;
    e_oe    = mvid && ph >= 5;
    check("R5 bus_pull_low", bus_pull_low, e_force);
    check("R6 addr_oe", addr_oe, e_oe);
    check("R7/R8 rom_addr", rom_addr, e_oe ? (mcode % 64) * 8 + mline : 0);
    check("R4 char_code", char_code, mcode);
    check("R3 video_cycle", video_cycle, mvid);
    force_cnt += bus_pull_low;
    oe_cnt    += addr_oe;
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic fetch(logic [7:0] d, bit a, bit h, int low_len, int exp_force, int exp_oe, string req);
    force_cnt = 0; oe_cnt = 0;
    m1_n = 0; data_in = d; a15 = a; halt_n = h;
    step(low_len);
    m1_n = 1; data_in = 8'hFF;
    step(10);
    check({req, " force clocks"}, force_cnt, exp_force);
    check({req, " drive clocks"}, oe_cnt, exp_oe);
  endtask

  task automatic hpulse();
    hsync = 1; step(); hsync = 0; step();
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(3);
    check("R1 reset force", bus_pull_low, 0);
    check("R1 reset code", char_code, 0);
    rst_n = 1; step();
    check("R1 after reset addr", rom_addr, 0);
    scen = "R2 R3 R7 display fetch";
    fetch(8'h2A, 1, 1, 5, 1, 3, "R5 R6");
    check("R4 captured", char_code, 8'h2A);
    scen = "R9 lines"; hpulse(); hpulse(); hpulse();
    scen = "R7 line 3";
    fetch(8'h3F, 1, 1, 5, 1, 3, "R6");
    scen = "R10 a15 low";  fetch(8'h11, 0, 1, 5, 0, 0, "R10");
    check("R10 code kept", char_code, 8'h3F);
    scen = "R10 halted";   fetch(8'h05, 1, 0, 5, 0, 0, "R10");
    scen = "R10 bit6 set"; fetch(8'h45, 1, 1, 5, 0, 0, "R10");
    check("R10 code kept", char_code, 8'h3F);
    scen = "R2 m1 short";  fetch(8'h07, 1, 1, 3, 0, 0, "R2");
    scen = "R11 long m1";  fetch(8'h15, 1, 1, 14, 1, 3, "R11");
    scen = "R9 wrap";
    for (int i = 0; i < 6; i++) hpulse();
    fetch(8'h01, 1, 1, 5, 1, 3, "R9");
    scen = "R9 vsync"; vsync = 1; step(2); hpulse(); vsync = 0; step();
    fetch(8'hBE, 1, 1, 5, 1, 3, "R7");
    scen = "R3 back to back";
    fetch(8'h22, 1, 1, 5, 1, 3, "R3");
    fetch(8'h23, 1, 1, 6, 1, 3, "R3");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule